// File: doc/BRIEF.md
# SPI Ferroelectric RAM Target

This block is an SPI target, in clock mode 0, that behaves like a small byte-addressed non-volatile RAM with no erase cycle. Any SPI master can use it as a model memory. Each chip-select-low period is one frame. The first byte of a frame is a command. A write-enable command arms a latch. A write command stores the data bytes that follow the address. A read command streams stored bytes back on MISO. During data, the address moves up by one after each byte and wraps at the end of the array.

The number of address bytes is a parameter, and the bytes arrive most significant first. A compact addressing scheme is used when there is a single address byte and the array holds more than 256 bytes. In that scheme the ninth address bit travels in bit 3 of the command byte. All SPI pins are sampled by the system clock, so SCLK must run several times slower than `clk`. A combinational backdoor port lets a checker read any array location without touching the SPI bus.

Top module: `fram_spi_slave`

## Requirements
- R1: While chip select is high, and from reset on, MISO is driven low, and the next frame starts by decoding a command byte.
- R2: Command 0x06 sets the write-enable latch. Any further bytes in that same frame are ignored.
- R3: Command 0x02 is followed by the address bytes, most significant first. The data bytes after the address are stored at consecutive addresses, starting at the one given.
- R4: A write command received while the latch is clear stores nothing. Any frame whose command is 0x02 clears the latch when chip select rises, even if the frame stored nothing or was cut short.
- R5: Command 0x03 is followed by the address. MISO then returns the stored bytes from consecutive addresses, most significant bit first. Each bit changes only after an SCLK falling edge, and the first bit appears after the falling edge that follows the last address bit.
- R6: The data address wraps from the last array location (0x1FF at the default size) to 0.
- R7: In compact mode, bit 3 of the command byte is address bit 8, and the command is decoded with bit 3 masked. So 0x0A is a write and 0x0B is a read in the upper 256 bytes.
- R8: Raising chip select at any point ends the frame. A partly shifted byte is dropped, and the next frame begins cleanly at bit 0.
- R9: A command byte other than 0x02, 0x03 or 0x06 makes the block ignore the rest of the frame. The write-enable latch keeps its value.
- R10: `bd_rdata` always shows the array byte at `bd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every SPI pin |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select, one frame per low period |
| mosi | input | 1 | Serial data in, sampled on SCLK rising edges |
| miso | output | 1 | Serial data out, updated after SCLK falling edges |
| bd_addr | input | ADDR_W | Backdoor read address |
| bd_rdata | output | 8 | Array byte at `bd_addr` |

## Verification
SCLK, MOSI and chip select each pass through one sampling register, and edge detection compares that register with the stage after it. A written byte therefore reaches the array two `clk` cycles after the eighth SCLK rise. A new MISO bit appears two cycles after an SCLK fall. The latch clears two cycles after chip select rises. The bench holds every SCLK phase for four `clk` cycles. It samples MISO just before each rising edge, which is four cycles after the preceding fall. It reads the backdoor only after chip select has been high for six cycles, so every result it checks has settled.

// File: rtl/fram_spi_slave.sv
module fram_spi_slave #(
  parameter int ADDR_W     = 9,
  parameter int ADDR_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [ADDR_W-1:0] bd_addr,
  output logic [7:0]        bd_rdata
);

  localparam int         DEPTH    = 1 << ADDR_W;
  localparam bit         COMPACT  = (ADDR_BYTES == 1) && (ADDR_W > 8);
  localparam int         ACC_W    = 8 * ADDR_BYTES;
  localparam int         WIDE_W   = ACC_W + 8;
  localparam logic [7:0] CMD_MASK = COMPACT ? 8'hF7 : 8'hFF;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA, ST_SKIP} state_t;

  state_t            state;
  logic [7:0]        mem [DEPTH];
  logic              sclk_s1, sclk_s2, cs_s1, cs_s2, mosi_s1;
  logic [2:0]        bit_cnt;
  logic [2:0]        abyte_cnt;
  logic [6:0]        shreg;
  logic [7:0]        tx;
  logic [ACC_W-1:0]  acc;
  logic [ADDR_W-1:0] addr;
  logic              wel, wr_frame, is_rd, a8, miso_r;

  wire              rise      = sclk_s1 & ~sclk_s2;
  wire              fall      = ~sclk_s1 & sclk_s2;
  wire              byte_done = rise & ~cs_s1 & (bit_cnt == 3'd7);
  wire [7:0]        rx_byte   = {shreg, mosi_s1};
  wire [7:0]        cmd       = rx_byte & CMD_MASK;
  wire              mem_we    = byte_done & (state == ST_WDATA);
  wire [7:0]        rd_word   = mem[addr];
  wire [ACC_W-1:0]  acc_next  = (acc << 8) | ACC_W'(rx_byte);
  wire [WIDE_W-1:0] wide      = {8'd0, acc_next} | (COMPACT ? (WIDE_W'(a8) << 8) : '0);
  wire [ADDR_W-1:0] addr_new  = ADDR_W'(wide);

  assign miso     = miso_r;
  assign bd_rdata = mem[bd_addr];

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s1   <= 1'b0;
      sclk_s2   <= 1'b0;
      cs_s1     <= 1'b1;
      cs_s2     <= 1'b1;
      mosi_s1   <= 1'b0;
      state     <= ST_CMD;
      bit_cnt   <= '0;
      abyte_cnt <= '0;
      shreg     <= '0;
      tx        <= '0;
      acc       <= '0;
      addr      <= '0;
      wel       <= 1'b0;
      wr_frame  <= 1'b0;
      is_rd     <= 1'b0;
      a8        <= 1'b0;
      miso_r    <= 1'b0;
    end else begin
      sclk_s1 <= sclk;
      sclk_s2 <= sclk_s1;
      cs_s1   <= cs_n;
      cs_s2   <= cs_s1;
      mosi_s1 <= mosi;
      if (cs_s1) begin
        state     <= ST_CMD;
        bit_cnt   <= '0;
        abyte_cnt <= '0;
        miso_r    <= 1'b0;
        wr_frame  <= 1'b0;
        if (wr_frame) wel <= 1'b0;
      end else begin
        if (rise) begin
          shreg   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          case (state)
            ST_CMD: begin
              a8        <= COMPACT & rx_byte[3];
              abyte_cnt <= '0;
              acc       <= '0;
              if (cmd == OP_WREN) begin
                wel   <= 1'b1;
                state <= ST_SKIP;
              end else if (cmd == OP_WRITE) begin
                wr_frame <= 1'b1;
                is_rd    <= 1'b0;
                state    <= wel ? ST_ADDR : ST_SKIP;
              end else if (cmd == OP_READ) begin
                is_rd <= 1'b1;
                state <= ST_ADDR;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              acc <= acc_next;
              if (abyte_cnt == 3'(ADDR_BYTES - 1)) begin
                addr  <= addr_new;
                state <= is_rd ? ST_RDATA : ST_WDATA;
              end else begin
                abyte_cnt <= abyte_cnt + 3'd1;
              end
            end
            ST_WDATA: addr <= addr + 1'b1;
            default: ;
          endcase
        end
        if (fall && state == ST_RDATA) begin
          if (bit_cnt == 3'd0) begin
            tx     <= rd_word;
            miso_r <= rd_word[7];
            addr   <= addr + 1'b1;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            miso_r <= tx[6];
          end
        end
      end
    end
  end

  // R4
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> wel);

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (cs_s1 && wr_frame) |=> !wel);

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s1 |=> (bit_cnt == 3'd0 && state == ST_CMD));

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_s1 |=> !miso);

  // R5
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !cs_s1) |=> $stable(miso));

  // R9
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP && !cs_s1) |=> (state == ST_SKIP && $stable(wel)));

endmodule

// File: tb/tb_fram_spi_slave.sv
module tb_fram_spi_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic [8:0] bd_addr = '0;
  logic [7:0] bd_rdata;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  fram_spi_slave #(.ADDR_W(9), .ADDR_BYTES(1)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .bd_addr(bd_addr), .bd_rdata(bd_rdata)
  );

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      tick(4);
      r[i] = miso;
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = 1'b1;
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic cs_hi();
    tick(4);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic wren();
    logic [7:0] r;
    cs_lo();
    xfer(8'h06, r);
    cs_hi();
  endtask

  task automatic wr_frame(input logic [8:0] a, input int n);
    logic [7:0] r;
    cs_lo();
    xfer(8'h02 | {4'd0, a[8], 3'd0}, r);
    xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(wbuf[k], r);
    cs_hi();
  endtask

  task automatic rd_frame(input logic [8:0] a, input int n);
    logic [7:0] r;
    cs_lo();
    xfer(8'h03 | {4'd0, a[8], 3'd0}, r);
    xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
    cs_hi();
  endtask

  task automatic bd(input logic [8:0] a, input string req, input logic [7:0] exp);
    bd_addr = a;
    tick(1);
    chk(req, {24'd0, bd_rdata}, {24'd0, exp});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1 miso after reset", {31'd0, miso}, 32'd0);
  endtask

  task automatic t_write();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    wren();
    wr_frame(9'h010, 4);
    bd(9'h010, "R3 byte0", 8'hA1);
    bd(9'h011, "R3 byte1", 8'hB2);
    bd(9'h013, "R3 byte3 R10", 8'hD4);
  endtask

  task automatic t_no_wel();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_frame(9'h010, 2);
    bd(9'h010, "R4 locked write 0", 8'hA1);
    bd(9'h011, "R4 locked write 1", 8'hB2);
  endtask

  task automatic t_read();
    rd_frame(9'h010, 4);
    chk("R5 read 0", {24'd0, rbuf[0]}, 32'hA1);
    chk("R5 read 1", {24'd0, rbuf[1]}, 32'hB2);
    chk("R5 read 3", {24'd0, rbuf[3]}, 32'hD4);
    chk("R1 miso idle after read", {31'd0, miso}, 32'd0);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C; wbuf[3] = 8'h8D;
    wren();
    wr_frame(9'h1FE, 4);
    bd(9'h1FF, "R7 upper half", 8'h6B);
    bd(9'h000, "R6 wrap write", 8'h7C);
    bd(9'h001, "R6 wrap write+1", 8'h8D);
    rd_frame(9'h1FF, 3);
    chk("R6 R7 read top", {24'd0, rbuf[0]}, 32'h6B);
    chk("R6 read wrapped", {24'd0, rbuf[1]}, 32'h7C);
    chk("R6 read wrapped+1", {24'd0, rbuf[2]}, 32'h8D);
    wbuf[0] = 8'hE7;
    wren();
    wr_frame(9'h100, 1);
    bd(9'h100, "R7 bit8 set", 8'hE7);
    bd(9'h000, "R7 bit8 clear untouched", 8'h7C);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    wbuf[0] = 8'h31; wbuf[1] = 8'h32;
    wren();
    wr_frame(9'h020, 2);
    wren();
    cs_lo();
    xfer(8'h02, r);
    xfer(8'h20, r);
    xfer(8'h99, r);
    bits(5);
    cs_hi();
    bd(9'h020, "R8 full byte kept", 8'h99);
    bd(9'h021, "R8 partial dropped", 8'h32);
    rd_frame(9'h020, 2);
    chk("R8 clean next frame 0", {24'd0, rbuf[0]}, 32'h99);
    chk("R8 clean next frame 1", {24'd0, rbuf[1]}, 32'h32);
    wbuf[0] = 8'h00;
    wr_frame(9'h021, 1);
    bd(9'h021, "R4 latch cleared by aborted write", 8'h32);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    wren();
    cs_lo();
    xfer(8'h55, r);
    xfer(8'h02, r);
    xfer(8'h21, r);
    xfer(8'h44, r);
    cs_hi();
    bd(9'h021, "R9 unknown command ignored", 8'h32);
    wbuf[0] = 8'h45;
    wr_frame(9'h021, 1);
    bd(9'h021, "R9 latch kept", 8'h45);
  endtask

  task automatic t_wren_tail();
    logic [7:0] r;
    cs_lo();
    xfer(8'h06, r);
    xfer(8'h02, r);
    xfer(8'h20, r);
    xfer(8'h77, r);
    cs_hi();
    bd(9'h020, "R2 trailing bytes ignored", 8'h99);
    wbuf[0] = 8'h88;
    wr_frame(9'h020, 1);
    bd(9'h020, "R2 latch set", 8'h88);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write();
    t_no_wel();
    t_read();
    t_wrap();
    t_abort();
    t_unknown();
    t_wren_tail();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule